// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the hardware-side state of a single circular descriptor ring that a DMA engine walks through. It holds the ring base address, the ring length and the two ring pointers. It turns them into an occupancy figure, a free-slot figure, empty and full flags, and the memory address of the descriptor that the engine should fetch next. Every descriptor takes 32 bytes. Both pointers are therefore shown as byte offsets whose low five bits are always zero.

Software reaches the block through a single-cycle register write port. The elaboration parameter `HW_PRODUCER` decides which pointer each side owns. With `HW_PRODUCER = 0` the hardware is the consumer: the host owns the write pointer and the engine advances the read pointer. With `HW_PRODUCER = 1` the roles swap, so the engine fills slots and the host hands them back. The engine asks to move its pointer one slot with `hw_adv`. The block answers with `adv_ack` in the same cycle whenever the move is taken. To tell a full ring from an empty one, one slot always stays unused.

Top module: `desc_ring_ptr`

## Requirements
- R1: After reset, both pointers are zero, the ring length is 2**IDX_W descriptors, the base address is zero, the field enables and the run flag are clear, and the ring reads empty.
- R2: A write with `reg_sel` = 1 loads the base address only if the base-enable flag is set. That flag is bit 2 of the last value written with `reg_sel` = 0. Otherwise the write has no effect.
- R3: A write with `reg_sel` = 2 carries the descriptor count shifted left by 3. It is taken only if the length-enable flag (bit 1 of the `reg_sel` = 0 value) is set and the count is between 2 and 2**IDX_W inclusive. An accepted length write also clears both pointers.
- R4: A write with `reg_sel` = 3 sets the host-owned pointer from a byte offset: index = value >> 5, and the low five bits are ignored. The write is dropped when the index is not below the ring length.
- R5: A write with `reg_sel` = 4 sets the run flag from bit 0. While the run flag is clear, `hw_adv` never moves a pointer.
- R6: A pointer that is advanced from index length-1 wraps to index 0.
- R7: `ring_empty` is high exactly when the pointers are equal. `ring_full` is high exactly when occupancy equals length-1. When `HW_PRODUCER = 0`, an advance request on an empty ring is ignored.
- R8: When `HW_PRODUCER = 1`, an advance request on a full ring is ignored.
- R9: If the write index is at least the read index, `free_slots` = length − (write − read). Otherwise `free_slots` = read − write. `occupancy` = length − `free_slots`.
- R10: `fetch_addr` equals the base address plus the byte offset of the hardware-owned pointer.
- R11: `adv_ack` is high in the cycle in which an advance request is taken, and the hardware pointer moves one slot at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 field enables, 1 base, 2 length, 3 host pointer, 4 run |
| reg_wdata | input | 32 | Register write data |
| hw_adv | input | 1 | Engine request to move its pointer one slot |
| adv_ack | output | 1 | Request taken this cycle |
| start_addr | output | ADDR_W | Ring base address |
| ring_depth | output | IDX_W+1 | Ring length in descriptors |
| wr_off | output | IDX_W+5 | Write pointer as byte offset |
| rd_off | output | IDX_W+5 | Read pointer as byte offset |
| occupancy | output | IDX_W+1 | Slots holding descriptors |
| free_slots | output | IDX_W+1 | Free-space count per R9 |
| ring_empty | output | 1 | Pointers equal |
| ring_full | output | 1 | Occupancy equals length-1 |
| fetch_addr | output | ADDR_W | Address of the next descriptor for the engine |

## Verification
The bench writes the base address and the ring length with the matching enable flag cleared. A design that ignored the enables would show the new value on `start_addr` or `ring_depth`. It also offers lengths of 1 and 128 and a host pointer at or beyond the end of the ring, which a design lacking bounds checks would accept, leaving a pointer outside the ring.

It drives the hardware pointer past the last slot and sets up a host pointer that trails the hardware one. A wrap or free-space calculation that got these wrong would show a pointer or a free count that had gone off the end of the ring. It also requests advances on an empty consumer ring, on a full producer ring and with the run flag clear. A design missing those guards would move its pointer, so that a full ring reads empty.

// File: rtl/drp_pkg.sv
package drp_pkg;

    typedef enum logic [2:0] {
        SEL_FEN     = 3'd0,
        SEL_START   = 3'd1,
        SEL_DEPTH   = 3'd2,
        SEL_HOSTPTR = 3'd3,
        SEL_RUN     = 3'd4
    } drp_sel_e;

    localparam int FEN_START_BIT = 2;
    localparam int FEN_DEPTH_BIT = 1;
    localparam int RUN_BIT       = 0;
    localparam int DESC_SHIFT    = 5;
    localparam int DEPTH_SHIFT   = 3;

endpackage

// File: rtl/drp_wrap_inc.sv
module drp_wrap_inc #(
    parameter int IDX_W = 6,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] depth,
    output logic [IDX_W-1:0] nxt
);
    logic [CNT_W-1:0] sum;

    always_comb begin
        sum = CNT_W'(idx) + CNT_W'(1);
        if (sum >= depth) begin
            nxt = '0;
        end else begin
            nxt = sum[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/drp_occupancy.sv
module drp_occupancy #(
    parameter int IDX_W = 6,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] free,
    output logic             empty,
    output logic             full
);
    always_comb begin
        if (wr_idx >= rd_idx) begin
            occ  = CNT_W'(wr_idx) - CNT_W'(rd_idx);
            free = depth - occ;
        end else begin
            free = CNT_W'(rd_idx) - CNT_W'(wr_idx);
            occ  = depth - free;
        end
        empty = (wr_idx == rd_idx);
        full  = (occ == depth - CNT_W'(1));
    end
endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr
    import drp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 6,
    parameter bit HW_PRODUCER = 1'b0,
    localparam int CNT_W = IDX_W + 1,
    localparam int OFF_W = IDX_W + DESC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              hw_adv,
    output logic              adv_ack,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  ring_depth,
    output logic [OFF_W-1:0]  wr_off,
    output logic [OFF_W-1:0]  rd_off,
    output logic [CNT_W-1:0]  occupancy,
    output logic [CNT_W-1:0]  free_slots,
    output logic              ring_empty,
    output logic              ring_full,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int MAX_DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [CNT_W-1:0]  depth;
        logic [IDX_W-1:0]  wr;
        logic [IDX_W-1:0]  rd;
        logic              fen_start;
        logic              fen_depth;
        logic              run;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0] hw_idx;
    logic [IDX_W-1:0] hw_nxt;
    logic             blocked;
    logic             depth_load;
    logic             ack_c;
    logic             run_on;
    logic [31:0]      cnt32;
    logic [31:0]      idx32;
    logic [OFF_W-1:0] hw_off;

    // Ring arithmetic
    drp_wrap_inc #(.IDX_W(IDX_W)) u_inc (
        .idx   (hw_idx),
        .depth (state_q.depth),
        .nxt   (hw_nxt)
    );

    drp_occupancy #(.IDX_W(IDX_W)) u_occ (
        .wr_idx (state_q.wr),
        .rd_idx (state_q.rd),
        .depth  (state_q.depth),
        .occ    (occupancy),
        .free   (free_slots),
        .empty  (ring_empty),
        .full   (ring_full)
    );

    // Role selection: which pointer the engine owns and what stalls it
    generate
        if (HW_PRODUCER) begin : g_producer
            assign hw_idx  = state_q.wr;
            assign blocked = ring_full;
        end else begin : g_consumer
            assign hw_idx  = state_q.rd;
            assign blocked = ring_empty;
        end
    endgenerate

    always_comb begin
        state_d    = state_q;
        depth_load = 1'b0;
        cnt32      = reg_wdata >> DEPTH_SHIFT;
        idx32      = reg_wdata >> DESC_SHIFT;

        if (reg_we) begin
            case (reg_sel)
                SEL_FEN: begin
                    state_d.fen_start = reg_wdata[FEN_START_BIT];
                    state_d.fen_depth = reg_wdata[FEN_DEPTH_BIT];
                end
                SEL_START: begin
                    if (state_q.fen_start) begin
                        state_d.start = reg_wdata[ADDR_W-1:0];
                    end
                end
                SEL_DEPTH: begin
                    if (state_q.fen_depth && (cnt32 >= 32'd2) &&
                        (cnt32 <= 32'(MAX_DEPTH))) begin
                        state_d.depth = cnt32[CNT_W-1:0];
                        state_d.wr    = '0;
                        state_d.rd    = '0;
                        depth_load    = 1'b1;
                    end
                end
                SEL_HOSTPTR: begin
                    if (idx32 < 32'(state_q.depth)) begin
                        if (HW_PRODUCER) begin
                            state_d.rd = idx32[IDX_W-1:0];
                        end else begin
                            state_d.wr = idx32[IDX_W-1:0];
                        end
                    end
                end
                SEL_RUN: begin
                    state_d.run = reg_wdata[RUN_BIT];
                end
                default: ;
            endcase
        end

        ack_c = hw_adv && state_q.run && !blocked && !depth_load;
        if (ack_c) begin
            if (HW_PRODUCER) begin
                state_d.wr = hw_nxt;
            end else begin
                state_d.rd = hw_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q           <= '0;
            state_q.depth     <= CNT_W'(MAX_DEPTH);
        end else begin
            state_q <= state_d;
        end
    end

    assign run_on     = state_q.run;
    assign adv_ack    = ack_c;
    assign start_addr = state_q.start;
    assign ring_depth = state_q.depth;
    assign wr_off     = {state_q.wr, {DESC_SHIFT{1'b0}}};
    assign rd_off     = {state_q.rd, {DESC_SHIFT{1'b0}}};
    assign hw_off     = {hw_idx, {DESC_SHIFT{1'b0}}};
    assign fetch_addr = state_q.start + ADDR_W'(hw_off);

endmodule

// File: rtl/drp_checker.sv
module drp_checker
    import drp_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter bit HW_PRODUCER = 1'b0,
    localparam int CNT_W = IDX_W + 1,
    localparam int OFF_W = IDX_W + DESC_SHIFT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic             hw_adv,
    input logic             adv_ack,
    input logic             ring_empty,
    input logic             ring_full,
    input logic [OFF_W-1:0] wr_off,
    input logic [OFF_W-1:0] rd_off,
    input logic [CNT_W-1:0] ring_depth,
    input logic             run_on
);
    logic [OFF_W-1:0] hw_off;
    logic             len_wr;

    assign hw_off = HW_PRODUCER ? wr_off : rd_off;
    assign len_wr = reg_we && (reg_sel == SEL_DEPTH);

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(wr_off[OFF_W-1:DESC_SHIFT]) < ring_depth) &&
        (CNT_W'(rd_off[OFF_W-1:DESC_SHIFT]) < ring_depth));

    a_r7_empty_full_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_empty && ring_full));

    a_r5_stopped_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |-> !adv_ack);

    a_r5_idle_holds_hw_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_adv && !len_wr) |=> $stable(hw_off));

    a_r11_ack_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ack && !len_wr) |=> (hw_off != $past(hw_off)));

    generate
        if (HW_PRODUCER) begin : g_prod_chk
            a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                (ring_full && hw_adv) |-> !adv_ack);
        end else begin : g_cons_chk
            a_r7_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                (ring_empty && hw_adv) |-> !adv_ack);
        end
    endgenerate
endmodule

bind desc_ring_ptr drp_checker #(
    .IDX_W       (IDX_W),
    .HW_PRODUCER (HW_PRODUCER)
) u_drp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .hw_adv     (hw_adv),
    .adv_ack    (adv_ack),
    .ring_empty (ring_empty),
    .ring_full  (ring_full),
    .wr_off     (wr_off),
    .rd_off     (rd_off),
    .ring_depth (ring_depth),
    .run_on     (run_on)
);

// File: tb/desc_ring_ptr_test.sv
`timescale 1ns/1ps
module desc_ring_ptr_test;
    import drp_pkg::*;

    localparam int IDX_W = 6;
    localparam int CNT_W = IDX_W + 1;
    localparam int OFF_W = IDX_W + 5;

    // observation codes
    localparam int C_WR = 0, C_RD = 1, C_FREE = 2, C_OCC = 3, C_FULL = 4,
                   C_EMPTY = 5, C_FETCH = 6, C_START = 7, C_DEPTH = 8, C_ACK = 9;

    typedef struct {
        string  req;
        int     p;
        int     code;
        longint exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic              we    [2];
    logic [2:0]        sel   [2];
    logic [31:0]       wdata [2];
    logic              adv   [2];
    logic              ack   [2];
    logic [31:0]       start [2];
    logic [CNT_W-1:0]  depth [2];
    logic [OFF_W-1:0]  wroff [2];
    logic [OFF_W-1:0]  rdoff [2];
    logic [CNT_W-1:0]  occ   [2];
    logic [CNT_W-1:0]  free  [2];
    logic              empty [2];
    logic              full  [2];
    logic [31:0]       fetch [2];

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    always #2.5 clk = ~clk;

    desc_ring_ptr #(.IDX_W(IDX_W), .HW_PRODUCER(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(we[0]), .reg_sel(sel[0]),
        .reg_wdata(wdata[0]), .hw_adv(adv[0]), .adv_ack(ack[0]),
        .start_addr(start[0]), .ring_depth(depth[0]), .wr_off(wroff[0]),
        .rd_off(rdoff[0]), .occupancy(occ[0]), .free_slots(free[0]),
        .ring_empty(empty[0]), .ring_full(full[0]), .fetch_addr(fetch[0]));

    desc_ring_ptr #(.IDX_W(IDX_W), .HW_PRODUCER(1'b1)) uut_prod (
        .clk(clk), .rst_n(rst_n), .reg_we(we[1]), .reg_sel(sel[1]),
        .reg_wdata(wdata[1]), .hw_adv(adv[1]), .adv_ack(ack[1]),
        .start_addr(start[1]), .ring_depth(depth[1]), .wr_off(wroff[1]),
        .rd_off(rdoff[1]), .occupancy(occ[1]), .free_slots(free[1]),
        .ring_empty(empty[1]), .ring_full(full[1]), .fetch_addr(fetch[1]));

    function automatic longint observe(int p, int code);
        case (code)
            C_WR:    return longint'(wroff[p]);
            C_RD:    return longint'(rdoff[p]);
            C_FREE:  return longint'(free[p]);
            C_OCC:   return longint'(occ[p]);
            C_FULL:  return longint'(full[p]);
            C_EMPTY: return longint'(empty[p]);
            C_FETCH: return longint'(fetch[p]);
            C_START: return longint'(start[p]);
            C_DEPTH: return longint'(depth[p]);
            default: return longint'(ack[p]);
        endcase
    endfunction

    // monitor: pops expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            longint got;
            it  = exp_q.pop_front();
            got = observe(it.p, it.code);
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s inst=%0d code=%0d actual=%0h expected=%0h",
                         it.req, it.p, it.code, got, it.exp);
            end
        end
    end

    task automatic push(string req, int p, int code, longint v);
        item_t it;
        it.req = req; it.p = p; it.code = code; it.exp = v;
        exp_q.push_back(it);
    endtask

    // expected ring view from the requirements (R7, R9, R10 formulas)
    task automatic expect_ring(int p, string req, int wr, int rd, int dep, longint st);
        int f;
        f = (wr >= rd) ? dep - (wr - rd) : rd - wr;
        push(req, p, C_WR, wr * 32);
        push(req, p, C_RD, rd * 32);
        push(req, p, C_DEPTH, dep);
        push(req, p, C_START, st);
        push(req, p, C_FREE, f);
        push(req, p, C_OCC, dep - f);
        push(req, p, C_EMPTY, (wr == rd) ? 1 : 0);
        push(req, p, C_FULL, ((dep - f) == dep - 1) ? 1 : 0);
        push(req, p, C_FETCH, (st + longint'((p == 1 ? wr : rd) * 32)) & 64'hFFFF_FFFF);
    endtask

    task automatic reg_wr(int p, logic [2:0] s, logic [31:0] v);
        @(posedge clk); #1;
        we[p] = 1'b1; sel[p] = s; wdata[p] = v;
        @(posedge clk); #1;
        we[p] = 1'b0; sel[p] = 3'd0; wdata[p] = 32'd0;
    endtask

    task automatic hw_step(int p, int exp_ack, string req);
        @(posedge clk); #1;
        adv[p] = 1'b1;
        push(req, p, C_ACK, exp_ack);
        @(posedge clk); #1;
        adv[p] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            we[i] = 1'b0; sel[i] = 3'd0; wdata[i] = 32'd0; adv[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of both variants
        expect_ring(0, "R1", 0, 0, 64, 0);
        expect_ring(1, "R1", 0, 0, 64, 0);

        // ---------------- consumer variant ----------------
        reg_wr(0, SEL_START, 32'h0000_1000);          // R2 enable clear
        expect_ring(0, "R2", 0, 0, 64, 0);
        reg_wr(0, SEL_FEN, 32'h4);
        reg_wr(0, SEL_START, 32'h8000_0000);          // R2 accepted
        expect_ring(0, "R2", 0, 0, 64, 32'h8000_0000);
        reg_wr(0, SEL_DEPTH, 32'd4 << 3);             // R3 length enable clear
        expect_ring(0, "R3", 0, 0, 64, 32'h8000_0000);
        reg_wr(0, SEL_FEN, 32'h2);
        reg_wr(0, SEL_DEPTH, 32'd1 << 3);             // R3 too short
        expect_ring(0, "R3", 0, 0, 64, 32'h8000_0000);
        reg_wr(0, SEL_DEPTH, 32'd128 << 3);           // R3 too long
        expect_ring(0, "R3", 0, 0, 64, 32'h8000_0000);
        reg_wr(0, SEL_DEPTH, 32'd4 << 3);             // R3 accepted
        expect_ring(0, "R3", 0, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_START, 32'h0000_1234);          // R2 base enable now clear
        expect_ring(0, "R2", 0, 0, 4, 32'h8000_0000);

        hw_step(0, 0, "R5");                          // R5 run flag clear
        expect_ring(0, "R5", 0, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_RUN, 32'h1);
        hw_step(0, 0, "R7");                          // R7 empty consumer stalls
        expect_ring(0, "R7", 0, 0, 4, 32'h8000_0000);

        reg_wr(0, SEL_HOSTPTR, 32'd96);               // wr=3 -> full
        expect_ring(0, "R7", 3, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_HOSTPTR, 32'd128);              // R4 index 4 >= length
        expect_ring(0, "R4", 3, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_HOSTPTR, 32'd71);               // R4 low bits dropped -> 2
        expect_ring(0, "R4", 2, 0, 4, 32'h8000_0000);

        reg_wr(0, SEL_RUN, 32'h0);
        hw_step(0, 0, "R5");
        expect_ring(0, "R5", 2, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_RUN, 32'h1);
        hw_step(0, 1, "R11");
        expect_ring(0, "R10", 2, 1, 4, 32'h8000_0000);
        hw_step(0, 1, "R11");
        expect_ring(0, "R7", 2, 2, 4, 32'h8000_0000);
        reg_wr(0, SEL_HOSTPTR, 32'd0);                // write index below read index
        expect_ring(0, "R9", 0, 2, 4, 32'h8000_0000);
        hw_step(0, 1, "R11");
        expect_ring(0, "R9", 0, 3, 4, 32'h8000_0000);
        hw_step(0, 1, "R6");
        expect_ring(0, "R6", 0, 0, 4, 32'h8000_0000);

        reg_wr(0, SEL_HOSTPTR, 32'd32);
        expect_ring(0, "R4", 1, 0, 4, 32'h8000_0000);
        reg_wr(0, SEL_DEPTH, 32'd8 << 3);             // R3 clears pointers
        expect_ring(0, "R3", 0, 0, 8, 32'h8000_0000);

        // ---------------- producer variant ----------------
        reg_wr(1, SEL_FEN, 32'h2);
        reg_wr(1, SEL_DEPTH, 32'd4 << 3);
        expect_ring(1, "R3", 0, 0, 4, 0);
        reg_wr(1, SEL_RUN, 32'h1);
        hw_step(1, 1, "R11");
        expect_ring(1, "R8", 1, 0, 4, 0);
        hw_step(1, 1, "R11");
        expect_ring(1, "R8", 2, 0, 4, 0);
        hw_step(1, 1, "R11");
        expect_ring(1, "R8", 3, 0, 4, 0);
        hw_step(1, 0, "R8");                          // R8 full producer stalls
        expect_ring(1, "R8", 3, 0, 4, 0);
        reg_wr(1, SEL_HOSTPTR, 32'd64);               // host returns up to slot 2
        expect_ring(1, "R4", 3, 2, 4, 0);
        hw_step(1, 1, "R6");
        expect_ring(1, "R6", 0, 2, 4, 0);
        hw_step(1, 1, "R11");
        expect_ring(1, "R10", 1, 2, 4, 0);

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule